// File: doc/BRIEF.md
# Compare-Driven Sync Pulse Timer

A free-running event timer for control loops. A wide counter adds a programmable step on every clock. Two compare registers watch it. The period compare closes the control period: the counter returns to zero and a period event is raised. The second compare marks a point inside the period where a sync output pulse of programmable width is launched. Because the counter moves several counts per clock, each compare is written as the target count minus the step. A compare hits when the current step reaches or crosses its value, so a value that is not a multiple of the step is still caught.

The sync pulse needs a global gate and a channel gate. In single-shot mode it fires once each time the channel is armed. In cyclic mode it fires on every sync-compare hit. Each compare sets a status flag. Software clears a flag by writing one to it, or hardware clears it in the next cycle when auto-clear is selected. A small register port configures the block, loads the counter, and reads the counter back as two 32-bit words that form one consistent snapshot.

Top module: `sync_event_timer`

## Requirements
- R1: After reset, `sync_o`, `cmp0_evt_o`, `cmp1_evt_o` and `rdata_o` are 0, and the counter reads 0 with a step of 0.
- R2: Each clock the counter adds the step held in bits 15:8 of the control word (address 0). A write to address 6 loads counter bits 31:0 and a write to address 7 loads bits 63:32. In a cycle that loads the counter, it does not step.
- R3: The period compare (address 1) hits when counter <= value < counter + step. With the period enable (control bit 2) set, `cmp0_evt_o` is high for one cycle in the cycle after the hit. If the wrap enable (control bit 0) is also set, the counter reads 0 in that same cycle.
- R4: While a compare's enable is clear (control bit 2 for the period compare, bit 3 for the sync compare), that compare raises no event, sets no flag, causes no wrap and launches no pulse.
- R5: A hit of the sync compare (address 2) that is allowed to fire raises `sync_o` in the same cycle as `cmp1_evt_o`. `sync_o` then stays high for (address 3 bits 15:0) + 1 cycles.
- R6: With the cyclic bit (address 4 bit 2) clear, one pulse fires per arming, and a write to address 4 with bit 1 set arms the channel. With the cyclic bit set, a pulse fires on every sync-compare hit.
- R7: No pulse fires unless both the global gate (address 4 bit 0) and the channel gate (address 4 bit 1) are set.
- R8: No pulse fires while the sync compare value is greater than or equal to the period compare value.
- R9: With auto-clear (control bit 1) set, a flag is cleared in the cycle after it is set, unless a new hit sets it again.
- R10: With auto-clear clear, flags (address 5: bit 0 period, bit 1 sync) stay set until a 1 is written to them. A hit in the same cycle as that write keeps the flag set.
- R11: A read returns data on `rdata_o` one cycle after `rd_en_i`, and `rdata_o` holds between reads. A read of address 6 returns counter bits 31:0 and captures bits 63:32. A later read of address 7 returns the captured bits, not the live ones.
- R12: A pulse that is still high when the counter wraps completes its full width. A sync-compare hit while a pulse is high launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read strobe |
| cmp0_evt_o | output | 1 | Period compare event pulse |
| cmp1_evt_o | output | 1 | Sync compare event pulse |
| sync_o | output | 1 | Sync output pulse |

## Verification
A software write-one-to-clear of the period flag can land in the same clock as a fresh period hit. The bench provokes this by locking onto one period event and then counting exactly one period minus one clock before it issues the clear. It then reads the flag back and expects it still set. A second collision is a sync-compare hit that arrives while a pulse is still high. The bench provokes it with a width longer than the period and judges it by measuring pulse widths and the spacing between rising edges. A behavioural model that runs clock by clock also checks every event, pulse and read at each cycle.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 3;
    localparam int INC_W  = 8;
    localparam int CMP_W  = 32;
    localparam int PW_W   = 16;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_PERIOD  = 3'd1;
    localparam logic [ADDR_W-1:0] A_SYNC_AT = 3'd2;
    localparam logic [ADDR_W-1:0] A_WIDTH   = 3'd3;
    localparam logic [ADDR_W-1:0] A_SYNC    = 3'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd6;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd7;

    typedef struct packed {
        logic             wrap_en;
        logic             auto_clr;
        logic [1:0]       cmp_en;
        logic [INC_W-1:0] inc;
        logic [CMP_W-1:0] period;
        logic [CMP_W-1:0] sync_at;
        logic [PW_W-1:0]  width;
        logic             glob_en;
        logic             ch_en;
        logic             cyclic;
    } stc_cfg_t;
endpackage

// File: rtl/stc_regs.sv
module stc_regs
    import stc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [1:0]        flags_i,
    output stc_cfg_t          cfg_o,
    output logic [REG_W-1:0]  rdata_o,
    output logic              arm_o,
    output logic [1:0]        clr_o,
    output logic              ld_lo_o,
    output logic              ld_hi_o
);
    localparam int HI_W = CNT_W - REG_W;

    typedef struct packed {
        stc_cfg_t         cfg;
        logic [REG_W-1:0] rdata;
        logic [HI_W-1:0]  shadow;
    } regs_t;

    regs_t s_d, s_q;

    // write strobes that act on state held elsewhere
    assign arm_o   = wr_en_i && (addr_i == A_SYNC) && wdata_i[1];
    assign clr_o   = (wr_en_i && (addr_i == A_FLAGS)) ? wdata_i[1:0] : 2'b00;
    assign ld_lo_o = wr_en_i && (addr_i == A_CNT_LO);
    assign ld_hi_o = wr_en_i && (addr_i == A_CNT_HI);

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            case (addr_i)
                A_CTRL: begin
                    s_d.cfg.wrap_en  = wdata_i[0];
                    s_d.cfg.auto_clr = wdata_i[1];
                    s_d.cfg.cmp_en   = wdata_i[3:2];
                    s_d.cfg.inc      = wdata_i[8 +: INC_W];
                end
                A_PERIOD:  s_d.cfg.period  = wdata_i[CMP_W-1:0];
                A_SYNC_AT: s_d.cfg.sync_at = wdata_i[CMP_W-1:0];
                A_WIDTH:   s_d.cfg.width   = wdata_i[PW_W-1:0];
                A_SYNC: begin
                    s_d.cfg.glob_en = wdata_i[0];
                    s_d.cfg.ch_en   = wdata_i[1];
                    s_d.cfg.cyclic  = wdata_i[2];
                end
                default: ;
            endcase
        end
        if (rd_en_i) begin
            case (addr_i)
                A_CTRL:    s_d.rdata = {16'h0, s_q.cfg.inc, 4'h0, s_q.cfg.cmp_en,
                                        s_q.cfg.auto_clr, s_q.cfg.wrap_en};
                A_PERIOD:  s_d.rdata = REG_W'(s_q.cfg.period);
                A_SYNC_AT: s_d.rdata = REG_W'(s_q.cfg.sync_at);
                A_WIDTH:   s_d.rdata = REG_W'(s_q.cfg.width);
                A_SYNC:    s_d.rdata = {29'h0, s_q.cfg.cyclic, s_q.cfg.ch_en, s_q.cfg.glob_en};
                A_FLAGS:   s_d.rdata = {30'h0, flags_i};
                A_CNT_LO: begin
                    s_d.rdata  = cnt_i[REG_W-1:0];
                    s_d.shadow = cnt_i[CNT_W-1:REG_W];
                end
                default:   s_d.rdata = REG_W'(s_q.shadow);
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cfg_o   = s_q.cfg;
    assign rdata_o = s_q.rdata;
endmodule

// File: rtl/stc_window.sv
module stc_window
    import stc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CMP_W-1:0] cmp_i,
    input  logic [INC_W-1:0] inc_i,
    input  logic             en_i,
    output logic             hit_o
);
    logic [CNT_W-1:0] tgt;
    logic [CNT_W-1:0] gap;

    // hit when this step lands on or jumps over the target
    always_comb begin
        tgt   = CNT_W'(cmp_i);
        gap   = tgt - cnt_i;
        hit_o = en_i && (inc_i != '0) && (cnt_i <= tgt) && (gap < CNT_W'(inc_i));
    end
endmodule

// File: rtl/stc_pulse.sv
module stc_pulse
    import stc_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            hit_i,
    input  logic            glob_en_i,
    input  logic            ch_en_i,
    input  logic            cyclic_i,
    input  logic            order_ok_i,
    input  logic            arm_i,
    input  logic [PW_W-1:0] width_i,
    output logic            sync_o
);
    typedef struct packed {
        logic            active;
        logic [PW_W-1:0] left;
        logic            armed;
    } pulse_t;

    pulse_t s_d, s_q;
    logic   start;

    always_comb begin
        s_d   = s_q;
        start = hit_i && glob_en_i && ch_en_i && order_ok_i
                && (cyclic_i || s_q.armed) && !s_q.active;
        if (arm_i)      s_d.armed = 1'b1;
        else if (start) s_d.armed = 1'b0;
        if (start) begin
            s_d.active = 1'b1;
            s_d.left   = width_i;
        end else if (s_q.active) begin
            if (s_q.left == '0) s_d.active = 1'b0;
            else                s_d.left   = s_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sync_o = s_q.active;
endmodule

// File: rtl/sync_event_timer.sv
module sync_event_timer
    import stc_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              cmp0_evt_o,
    output logic              cmp1_evt_o,
    output logic              sync_o
);
    localparam int HI_W  = CNT_W - REG_W;
    localparam int N_CMP = 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [N_CMP-1:0] flags;
        logic [N_CMP-1:0] evt;
    } core_t;

    core_t            s_d, s_q;
    stc_cfg_t         cfg;
    logic             arm;
    logic [1:0]       clr_req;
    logic             ld_lo, ld_hi;
    logic             cnt_load;
    logic             order_ok;
    logic [N_CMP-1:0] hit;
    logic [CNT_W-1:0] cnt_w;
    logic [N_CMP-1:0] flags_w;

    stc_regs #(.CNT_W(CNT_W)) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .cnt_i   (s_q.cnt),
        .flags_i (s_q.flags),
        .cfg_o   (cfg),
        .rdata_o (rdata_o),
        .arm_o   (arm),
        .clr_o   (clr_req),
        .ld_lo_o (ld_lo),
        .ld_hi_o (ld_hi)
    );

    for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
        stc_window #(.CNT_W(CNT_W)) u_win (
            .cnt_i (s_q.cnt),
            .cmp_i ((i == 0) ? cfg.period : cfg.sync_at),
            .inc_i (cfg.inc),
            .en_i  (cfg.cmp_en[i]),
            .hit_o (hit[i])
        );
    end

    assign order_ok = cfg.sync_at < cfg.period;
    assign cnt_load = ld_lo || ld_hi;

    stc_pulse u_pulse (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hit_i      (hit[1]),
        .glob_en_i  (cfg.glob_en),
        .ch_en_i    (cfg.ch_en),
        .cyclic_i   (cfg.cyclic),
        .order_ok_i (order_ok),
        .arm_i      (arm),
        .width_i    (cfg.width),
        .sync_o     (sync_o)
    );

    always_comb begin
        s_d     = s_q;
        s_d.evt = hit;
        for (int i = 0; i < N_CMP; i++) begin
            // a fresh hit outranks any clear
            s_d.flags[i] = hit[i] || (s_q.flags[i] && !(cfg.auto_clr || clr_req[i]));
        end
        if (cnt_load) begin
            if (ld_lo) s_d.cnt[REG_W-1:0]     = wdata_i;
            if (ld_hi) s_d.cnt[CNT_W-1:REG_W] = wdata_i[HI_W-1:0];
        end else if (hit[0] && cfg.wrap_en) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(cfg.inc);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign cmp0_evt_o = s_q.evt[0];
    assign cmp1_evt_o = s_q.evt[1];
    assign cnt_w      = s_q.cnt;
    assign flags_w    = s_q.flags;
endmodule

// File: rtl/stc_checker.sv
module stc_checker #(
    parameter int CNT_W = 64
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             cmp0_evt,
    input logic             cmp1_evt,
    input logic             sync,
    input logic [1:0]       flags,
    input logic [CNT_W-1:0] cnt,
    input logic             wrap_en,
    input logic             auto_clr,
    input logic             en0,
    input logic             glob_en,
    input logic             ch_en,
    input logic             order_ok,
    input logic             cnt_load
);
    // R3
    period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp0_evt && $past(wrap_en) && !$past(cnt_load)) |-> (cnt == '0));

    // R4
    cmp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en0) |-> !cmp0_evt);

    // R5
    sync_launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync) |-> cmp1_evt);

    // R7
    sync_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync) |-> $past(glob_en && ch_en));

    // R8
    sync_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sync) |-> $past(order_ok));

    // R9
    auto_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(auto_clr) && $past(flags[0]) && !cmp0_evt) |-> !flags[0]);

    // R10
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp0_evt |-> flags[0]) and (cmp1_evt |-> flags[1]));
endmodule

bind sync_event_timer stc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp0_evt (cmp0_evt_o),
    .cmp1_evt (cmp1_evt_o),
    .sync     (sync_o),
    .flags    (flags_w),
    .cnt      (cnt_w),
    .wrap_en  (cfg.wrap_en),
    .auto_clr (cfg.auto_clr),
    .en0      (cfg.cmp_en[0]),
    .glob_en  (cfg.glob_en),
    .ch_en    (cfg.ch_en),
    .order_ok (order_ok),
    .cnt_load (cnt_load)
);

// File: tb/sync_event_timer_bench.sv
`timescale 1ns/1ps
module sync_event_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        cmp0_evt, cmp1_evt, sync_out;

    sync_event_timer u_sync_event_timer (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
        .cmp0_evt_o(cmp0_evt), .cmp1_evt_o(cmp1_evt), .sync_o(sync_out)
    );

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [63:0] m_cnt;
    bit m_wrap, m_auto, m_en0, m_en1, m_glob, m_s0, m_cyc, m_sync, m_armed, m_e0, m_e1;
    bit [7:0]  m_inc;
    bit [31:0] m_per, m_at, m_rd, m_sh;
    bit [15:0] m_wid;
    bit [1:0]  m_flag;
    int m_left;

    function automatic bit reaches(logic [63:0] c, bit [31:0] cmp, bit [7:0] inc);
        logic [63:0] t;
        t = {32'h0, cmp};
        if (inc == 0 || c > t) return 0;
        return (t - c) < {56'h0, inc};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; {m_wrap, m_auto, m_en0, m_en1, m_glob, m_s0, m_cyc} = 0;
            m_sync = 0; m_armed = 0; m_e0 = 0; m_e1 = 0; m_inc = 0; m_per = 0;
            m_at = 0; m_rd = 0; m_sh = 0; m_wid = 0; m_flag = 0; m_left = 0;
        end else begin
            bit h0, h1, start, arm;
            bit [1:0] wc;
            h0 = m_en0 && reaches(m_cnt, m_per, m_inc);
            h1 = m_en1 && reaches(m_cnt, m_at, m_inc);
            arm = wr_en && addr == 4 && wdata[1];
            start = h1 && m_glob && m_s0 && (m_cyc || m_armed) && !m_sync && (m_at < m_per);
            wc = (wr_en && addr == 5) ? wdata[1:0] : 2'b00;
            if (rd_en) begin
                case (addr)
                    0: m_rd = {16'h0, m_inc, 4'h0, m_en1, m_en0, m_auto, m_wrap};
                    1: m_rd = m_per;
                    2: m_rd = m_at;
                    3: m_rd = {16'h0, m_wid};
                    4: m_rd = {29'h0, m_cyc, m_s0, m_glob};
                    5: m_rd = {30'h0, m_flag};
                    6: begin m_rd = m_cnt[31:0]; m_sh = m_cnt[63:32]; end
                    default: m_rd = m_sh;
                endcase
            end
            m_flag[0] = h0 | (m_flag[0] & !(m_auto | wc[0]));
            m_flag[1] = h1 | (m_flag[1] & !(m_auto | wc[1]));
            m_e0 = h0; m_e1 = h1;
            if (wr_en && addr == 6) m_cnt[31:0] = wdata;
            else if (wr_en && addr == 7) m_cnt[63:32] = wdata;
            else if (h0 && m_wrap) m_cnt = 0;
            else m_cnt = m_cnt + m_inc;
            if (start) begin m_sync = 1; m_left = m_wid; end
            else if (m_sync) begin
                if (m_left == 0) m_sync = 0; else m_left--;
            end
            if (arm) m_armed = 1; else if (start) m_armed = 0;
            if (wr_en) begin
                case (addr)
                    0: begin m_wrap = wdata[0]; m_auto = wdata[1]; m_en0 = wdata[2];
                             m_en1 = wdata[3]; m_inc = wdata[15:8]; end
                    1: m_per = wdata;
                    2: m_at = wdata;
                    3: m_wid = wdata[15:0];
                    4: begin m_glob = wdata[0]; m_s0 = wdata[1]; m_cyc = wdata[2]; end
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sync_out === m_sync, "R5 sync_o vs model", sync_out, m_sync);
            chk(cmp0_evt === m_e0, "R3 cmp0_evt_o vs model", cmp0_evt, m_e0);
            chk(cmp1_evt === m_e1, "R4 cmp1_evt_o vs model", cmp1_evt, m_e1);
            chk(rdata === m_rd, "R11 rdata_o vs model", rdata, m_rd);
        end
    end

    // pulse / event monitor
    int cyc = 0, cur = 0;
    bit prev_s = 0;
    int rises[$], widths[$], e0t[$];
    always @(negedge clk) begin
        cyc++;
        if (cmp0_evt) e0t.push_back(cyc);
        if (sync_out) begin
            if (!prev_s) begin rises.push_back(cyc); cur = 0; end
            cur++;
        end else if (prev_s) widths.push_back(cur);
        prev_s = sync_out;
    end

    task automatic tick; @(negedge clk); #1; endtask
    task automatic idle(input int n); repeat (n) tick(); endtask
    task automatic wr(input bit [2:0] a, input bit [31:0] d);
        wr_en = 1; addr = a; wdata = d; tick(); wr_en = 0;
    endtask
    task automatic rd(input bit [2:0] a, output bit [31:0] d);
        rd_en = 1; addr = a; tick(); rd_en = 0; d = rdata;
    endtask
    task automatic clr_q; rises.delete(); widths.delete(); e0t.delete(); endtask
    task automatic gaps(input int q[$], input int gap, input string tag);
        for (int i = 1; i < q.size(); i++)
            chk(q[i] - q[i-1] == gap, tag, q[i] - q[i-1], gap);
    endtask
    task automatic cnt_zero; wr(7, 0); wr(6, 0); endtask
    task automatic settle; while (sync_out) tick(); endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #750000;
        if (!done) begin
            done = 1;
            chk(0, "watchdog expired", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        bit [31:0] v1, v2;
        idle(4);
        // R1 reset state
        chk(sync_out == 0 && cmp0_evt == 0 && cmp1_evt == 0, "R1 outputs in reset",
            {sync_out, cmp0_evt, cmp1_evt}, 0);
        chk(rdata == 0, "R1 rdata in reset", rdata, 0);
        rst_n = 1;
        tick();
        rd(6, v1);
        idle(3);
        rd(6, v2);
        chk(v1 == 0 && v2 == 0, "R1 counter idle at step 0", v2, 0);

        // R2 stepping
        wr(0, 32'h0400);
        rd(6, v1);
        idle(9);
        rd(6, v2);
        chk(v2 - v1 == 40, "R2 step of 4 over 10 cycles", v2 - v1, 40);

        // R2 load, R11 snapshot across a carry
        wr(7, 5);
        wr(6, 32'hFFFF_FFE0);
        rd(6, v1);
        chk(v1 == 32'hFFFF_FFE0, "R2 low word load", v1, 32'hFFFF_FFE0);
        idle(20);
        rd(7, v2);
        chk(v2 == 5, "R11 high word from snapshot", v2, 5);
        rd(6, v1);
        rd(7, v2);
        chk(v2 == 6, "R11 high word after carry", v2, 6);

        // R3 period with exact and non-multiple compare values
        wr(1, 96);
        wr(0, 32'h0405);
        cnt_zero();
        clr_q(); idle(120);
        chk(e0t.size() >= 4, "R3 period events seen", e0t.size(), 4);
        gaps(e0t, 25, "R3 period spacing exact");
        wr(1, 98);
        clr_q(); idle(120);
        chk(e0t.size() >= 4, "R3 events with non-multiple compare", e0t.size(), 4);
        gaps(e0t, 25, "R3 period spacing non-multiple");

        // R4 disabled period compare
        wr(0, 32'h0401);
        clr_q(); idle(60);
        chk(e0t.size() == 0, "R4 no event when disabled", e0t.size(), 0);
        rd(6, v1);
        chk(v1 > 98, "R4 no wrap when disabled", v1, 99);

        // R5 / R6 single-shot
        wr(1, 96); wr(2, 36); wr(3, 9); wr(4, 0);
        wr(0, 32'h040D);
        cnt_zero();
        clr_q();
        wr(4, 3);
        idle(100);
        chk(rises.size() == 1, "R6 single-shot fires once", rises.size(), 1);
        chk(widths.size() == 1 && widths[0] == 10, "R5 width 9+1 cycles",
            widths.size() ? widths[0] : -1, 10);
        clr_q();
        wr(4, 3);
        idle(100);
        chk(rises.size() == 1, "R6 re-arm fires once more", rises.size(), 1);

        // R6 cyclic
        wr(4, 7);
        clr_q(); idle(120);
        chk(rises.size() >= 4, "R6 cyclic fires each period", rises.size(), 4);
        gaps(rises, 25, "R6 cyclic spacing");
        foreach (widths[i]) chk(widths[i] == 10, "R5 cyclic width", widths[i], 10);

        // R7 gates
        wr(4, 6);
        settle(); clr_q(); idle(60);
        chk(rises.size() == 0, "R7 global gate off", rises.size(), 0);
        wr(4, 5);
        settle(); clr_q(); idle(60);
        chk(rises.size() == 0, "R7 channel gate off", rises.size(), 0);
        // R4 disabled sync compare
        wr(4, 7); wr(0, 32'h0405);
        settle(); clr_q(); idle(60);
        chk(rises.size() == 0, "R4 sync compare disabled", rises.size(), 0);
        wr(0, 32'h040D);

        // R8 ordering
        wr(2, 96);
        settle(); clr_q(); idle(60);
        chk(rises.size() == 0, "R8 sync equal to period", rises.size(), 0);
        wr(2, 300);
        settle(); clr_q(); idle(60);
        chk(rises.size() == 0, "R8 sync beyond period", rises.size(), 0);

        // R10 sticky flag, clear, and set-over-clear
        wr(0, 32'h0405);
        while (!cmp0_evt) tick();
        idle(3);
        rd(5, v1);
        chk(v1[0] == 1, "R10 flag sticky", v1[0], 1);
        wr(5, 1);
        rd(5, v1);
        chk(v1[0] == 0, "R10 write-one clears", v1[0], 0);
        while (!cmp0_evt) tick();
        idle(24);
        wr(5, 1);
        chk(cmp0_evt == 1, "R10 clear lands on a hit", cmp0_evt, 1);
        rd(5, v1);
        chk(v1[0] == 1, "R10 hit wins over clear", v1[0], 1);

        // R9 auto-clear
        wr(0, 32'h0407);
        while (!cmp0_evt) tick();
        idle(2);
        rd(5, v1);
        chk(v1[0] == 0, "R9 flag auto-cleared", v1[0], 0);

        // R12 pulse across wrap, and overlapping hit ignored
        wr(2, 88); wr(3, 19); wr(0, 32'h040D); wr(4, 7);
        cnt_zero();
        idle(40); settle(); clr_q(); idle(100); settle();
        chk(widths.size() >= 3, "R12 pulses across wrap", widths.size(), 3);
        foreach (widths[i]) chk(widths[i] == 20, "R12 full width across wrap", widths[i], 20);
        wr(3, 29);
        idle(30); settle(); clr_q(); idle(200); settle();
        chk(rises.size() >= 3, "R12 long pulses", rises.size(), 3);
        gaps(rises, 50, "R12 hit during pulse ignored");
        foreach (widths[i]) chk(widths[i] == 30, "R12 long width", widths[i], 30);

        done = 1;
        summary();
        $finish;
    end
endmodule